// File: doc/BRIEF.md
# Dual-Accumulator Arithmetic and Shift Unit

This unit executes the register-to-register operations of a 12-bit processor. It holds two main accumulators, J and K, two sub-accumulators, R and S, and an overflow bit. Each instruction word that arrives with its valid strobe is decoded and applied in a single clock. The unit covers bitwise AND, add and subtract pairings with an optional negation, left shifts and rotates of a single accumulator or of the joined 24-bit pair, and moves or swaps between the main accumulators and the sub-accumulators. A separate switch input can be copied into J.

Only words whose top four bits are `0010` (octal 1000 to 1377) belong to this unit. Bits 7 and 6 select the destination: bit 7 selects K and bit 6 selects J. Bits 5 and 4 select the operation class. Encodings that no operation claims are ignored. Multiply, divide, memory traffic and status assembly are handled elsewhere.

Top module: `ac_unit`

## Requirements
- R1: While reset is asserted, J, K, R, S and the overflow bit are all zero.
- R2: A word changes state only when `op_valid` is high and bits 11:8 are `0010`. Encodings in that range that no requirement below assigns leave all five registers unchanged. These include octal 1000 and 1001, arithmetic selectors 6 and 7, and codes whose bits 7:6 are `00` other than 1010.
- R3: Bit 7 selects K and bit 6 selects J. An accumulator that is not selected keeps its value.
- R4: With bits 5:0 zero, J AND K is written to the selected accumulator(s): 1100 writes J, 1200 writes K and 1300 writes both.
- R5: With bits 5:4 = `01`, bits 2:0 select the operation: 0 gives J+K, 1 gives J−K, 2 gives R+A, 3 gives R−A, 4 gives S+A and 5 gives S−A. A is K when only K is selected and J otherwise. When both accumulators are selected, only selectors 0 and 1 are valid.
- R6: Bit 3 set in an arithmetic word stores the two's-complement negation of the R5 result.
- R7: An arithmetic word loads the overflow bit with the signed 12-bit overflow of the add or subtract, ORed with the case where negation is applied to −2048. No other word changes the overflow bit.
- R8: With bits 5:4 = `10`, a single selected accumulator is shifted left by the count in bits 3:0, with zeros filling from the right. A count of 12 or more clears it, and a count of 0 leaves it unchanged.
- R9: With bits 5:4 = `11`, a single selected accumulator is rotated left by the count in bits 3:0, taken modulo 12.
- R10: With both accumulators selected, a shift or rotate acts on the 24-bit value {J,K}, with J as the upper word. Code 1374 therefore swaps J and K.
- R11: The transfer codes behave as follows:
  - 1101 copies J into R, 1102 copies R into J and 1103 swaps J and R.
  - 1201 copies K into S, 1202 copies S into K and 1203 swaps K and S.
  - 1204 copies J into K.
  - 1301, 1302 and 1303 apply copy-to-sub, copy-from-sub and swap to both pairs at once.
  - R and S change under no other word.
- R12: Code 1010 loads J from `switch_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Instruction strobe |
| op_word | input | 12 | Instruction word |
| switch_word | input | 12 | Value copied into J by code 1010 |
| j_out | output | 12 | Accumulator J |
| k_out | output | 12 | Accumulator K |
| r_out | output | 12 | Sub-accumulator R |
| s_out | output | 12 | Sub-accumulator S |
| ovf_out | output | 1 | Overflow bit |

## Verification
The assertions check several properties on every cycle. All state holds when no strobe is present. R and S move only under transfer words, and the overflow bit moves only under arithmetic words. K holds when it is not a destination. A negation of −2048 always leaves overflow set, and code 1374 swaps J and K. The exact arithmetic, shift and rotate values, the selection of R or S and of the partner accumulator, and overflow at the signed boundaries can only be shown by the bench. It applies every one of the 256 words of the group to a set of register states that includes 0, −1, 2047 and −2048. It then compares all five registers against its own arithmetic model.

// File: rtl/ac_pkg.sv
package ac_pkg;

  localparam int OPW = 12;

  typedef enum logic [2:0] {
    K_NONE,
    K_AND,
    K_XFER,
    K_ARITH,
    K_SHIFT,
    K_ROTATE,
    K_SWITCH
  } op_kind_e;

  typedef enum logic [1:0] {
    XF_TO_SUB,
    XF_FROM_SUB,
    XF_SWAP,
    XF_K_FROM_J
  } xfer_e;

  typedef struct packed {
    op_kind_e    kind;
    logic        wr_j;
    logic        wr_k;
    logic [2:0]  sel;
    logic        negate;
    logic [3:0]  count;
    xfer_e       xfer;
  } op_t;

endpackage

// File: rtl/ac_decode.sv
module ac_decode
  import ac_pkg::*;
(
  input  logic [OPW-1:0] word,
  output op_t            op
);

  logic [1:0] dest;
  logic [1:0] mode;
  logic [3:0] low;
  logic       in_group;

  assign in_group = (word[11:8] == 4'b0010);
  assign dest     = word[7:6];
  assign mode     = word[5:4];
  assign low      = word[3:0];

  always_comb begin
    op        = '0;
    op.kind   = K_NONE;
    op.xfer   = XF_TO_SUB;
    op.sel    = word[2:0];
    op.negate = word[3];
    op.count  = low;
    if (in_group) begin
      unique case (mode)
        2'b00: begin
          if (dest == 2'b00) begin
            if (low == 4'd8) begin
              op.kind = K_SWITCH;
              op.wr_j = 1'b1;
            end
          end else if (low == 4'd0) begin
            op.kind = K_AND;
            op.wr_j = dest[0];
            op.wr_k = dest[1];
          end else if (low == 4'd1 || low == 4'd2 || low == 4'd3) begin
            op.kind = K_XFER;
            op.wr_j = dest[0];
            op.wr_k = dest[1];
            op.xfer = (low == 4'd1) ? XF_TO_SUB :
                      (low == 4'd2) ? XF_FROM_SUB : XF_SWAP;
          end else if (low == 4'd4 && dest == 2'b10) begin
            op.kind = K_XFER;
            op.wr_k = 1'b1;
            op.xfer = XF_K_FROM_J;
          end
        end
        2'b01: begin
          if (dest != 2'b00 && word[2:0] <= 3'd5 &&
              !(dest == 2'b11 && word[2:0] > 3'd1)) begin
            op.kind = K_ARITH;
            op.wr_j = dest[0];
            op.wr_k = dest[1];
          end
        end
        default: begin
          if (dest != 2'b00) begin
            op.kind = mode[0] ? K_ROTATE : K_SHIFT;
            op.wr_j = dest[0];
            op.wr_k = dest[1];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ac_arith.sv
module ac_arith #(
  parameter int W = 12
) (
  input  logic [W-1:0] j,
  input  logic [W-1:0] k,
  input  logic [W-1:0] r,
  input  logic [W-1:0] s,
  input  logic [2:0]   sel,
  input  logic         negate,
  input  logic         use_k,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         neg_wrap
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  // {overflow, sum} of a +/- b in W-bit two's complement
  function automatic logic [W:0] addsub(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic         sub);
    logic [W-1:0] bb;
    logic [W-1:0] sum;
    logic         ov;
    bb  = sub ? ~b : b;
    sum = a + bb + W'(sub);
    ov  = (a[W-1] == bb[W-1]) && (sum[W-1] != a[W-1]);
    return {ov, sum};
  endfunction

  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] v);
    return ~v + W'(1);
  endfunction

  logic [W-1:0] acc, opa, opb, raw;
  logic         do_sub, raw_ovf;

  assign acc = use_k ? k : j;

  always_comb begin
    opa    = j;
    opb    = k;
    do_sub = 1'b0;
    unique case (sel)
      3'd1:    do_sub = 1'b1;
      3'd2:    begin opa = r; opb = acc; end
      3'd3:    begin opa = r; opb = acc; do_sub = 1'b1; end
      3'd4:    begin opa = s; opb = acc; end
      3'd5:    begin opa = s; opb = acc; do_sub = 1'b1; end
      default: ;
    endcase
  end

  assign {raw_ovf, raw} = addsub(opa, opb, do_sub);
  assign neg_wrap       = negate && (raw == MOST_NEG);
  assign result         = negate ? twos_neg(raw) : raw;
  assign ovf            = raw_ovf | neg_wrap;

endmodule

// File: rtl/ac_shift.sv
module ac_shift #(
  parameter int W = 12
) (
  input  logic [W-1:0] j,
  input  logic [W-1:0] k,
  input  logic [3:0]   count,
  input  logic         rotate,
  input  logic         wr_j,
  input  logic         wr_k,
  output logic [W-1:0] new_j,
  output logic [W-1:0] new_k
);

  localparam int PW   = 2 * W;
  localparam int SAW  = $clog2(W);
  localparam int PSAW = $clog2(PW);

  function automatic logic [W-1:0] word_op(input logic [W-1:0] v,
                                           input logic [3:0]   n,
                                           input logic         rot);
    logic [2*W-1:0] dbl;
    logic [SAW-1:0] amt;
    amt = SAW'(int'(n) % W);
    dbl = {v, v} << amt;
    return rot ? dbl[2*W-1:W] : (v << n);
  endfunction

  function automatic logic [PW-1:0] pair_op(input logic [PW-1:0] v,
                                            input logic [3:0]    n,
                                            input logic          rot);
    logic [2*PW-1:0] dbl;
    logic [PSAW-1:0] amt;
    amt = PSAW'(int'(n) % PW);
    dbl = {v, v} << amt;
    return rot ? dbl[2*PW-1:PW] : (v << n);
  endfunction

  logic [PW-1:0] pair_res;
  logic [W-1:0]  j_res, k_res;

  assign pair_res = pair_op({j, k}, count, rotate);
  assign j_res    = word_op(j, count, rotate);
  assign k_res    = word_op(k, count, rotate);

  always_comb begin
    new_j = j;
    new_k = k;
    if (wr_j && wr_k) begin
      {new_j, new_k} = pair_res;
    end else if (wr_j) begin
      new_j = j_res;
    end else if (wr_k) begin
      new_k = k_res;
    end
  end

endmodule

// File: rtl/ac_unit.sv
module ac_unit
  import ac_pkg::*;
#(
  parameter int W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_word,
  input  logic [W-1:0]   switch_word,
  output logic [W-1:0]   j_out,
  output logic [W-1:0]   k_out,
  output logic [W-1:0]   r_out,
  output logic [W-1:0]   s_out,
  output logic           ovf_out
);

  op_t          dec;
  logic [W-1:0] j_q, k_q, r_q, s_q;
  logic         ov_q;
  logic [W-1:0] j_d, k_d, r_d, s_d;
  logic         ov_d;
  logic [W-1:0] arith_res, sh_j, sh_k;
  logic         arith_ovf, arith_neg_wrap;

  // named events for the checker
  logic op_is_xfer, op_is_arith, op_writes_k;

  ac_decode u_dec (
    .word (op_word),
    .op   (dec)
  );

  ac_arith #(.W(W)) u_arith (
    .j        (j_q),
    .k        (k_q),
    .r        (r_q),
    .s        (s_q),
    .sel      (dec.sel),
    .negate   (dec.negate),
    .use_k    (dec.wr_k && !dec.wr_j),
    .result   (arith_res),
    .ovf      (arith_ovf),
    .neg_wrap (arith_neg_wrap)
  );

  ac_shift #(.W(W)) u_shift (
    .j      (j_q),
    .k      (k_q),
    .count  (dec.count),
    .rotate (dec.kind == K_ROTATE),
    .wr_j   (dec.wr_j),
    .wr_k   (dec.wr_k),
    .new_j  (sh_j),
    .new_k  (sh_k)
  );

  assign op_is_xfer  = op_valid && (dec.kind == K_XFER);
  assign op_is_arith = op_valid && (dec.kind == K_ARITH);
  assign op_writes_k = dec.wr_k;

  always_comb begin
    j_d  = j_q;
    k_d  = k_q;
    r_d  = r_q;
    s_d  = s_q;
    ov_d = ov_q;
    if (op_valid) begin
      unique case (dec.kind)
        K_AND: begin
          if (dec.wr_j) j_d = j_q & k_q;
          if (dec.wr_k) k_d = j_q & k_q;
        end
        K_XFER: begin
          unique case (dec.xfer)
            XF_TO_SUB: begin
              if (dec.wr_j) r_d = j_q;
              if (dec.wr_k) s_d = k_q;
            end
            XF_FROM_SUB: begin
              if (dec.wr_j) j_d = r_q;
              if (dec.wr_k) k_d = s_q;
            end
            XF_SWAP: begin
              if (dec.wr_j) begin j_d = r_q; r_d = j_q; end
              if (dec.wr_k) begin k_d = s_q; s_d = k_q; end
            end
            default: k_d = j_q;
          endcase
        end
        K_ARITH: begin
          if (dec.wr_j) j_d = arith_res;
          if (dec.wr_k) k_d = arith_res;
          ov_d = arith_ovf;
        end
        K_SHIFT, K_ROTATE: begin
          j_d = sh_j;
          k_d = sh_k;
        end
        K_SWITCH: j_d = switch_word;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      j_q  <= '0;
      k_q  <= '0;
      r_q  <= '0;
      s_q  <= '0;
      ov_q <= 1'b0;
    end else begin
      j_q  <= j_d;
      k_q  <= k_d;
      r_q  <= r_d;
      s_q  <= s_d;
      ov_q <= ov_d;
    end
  end

  assign j_out   = j_q;
  assign k_out   = k_q;
  assign r_out   = r_q;
  assign s_out   = s_q;
  assign ovf_out = ov_q;

endmodule

// File: rtl/ac_unit_chk.sv
module ac_unit_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [11:0]  op_word,
  input logic [W-1:0] j_out,
  input logic [W-1:0] k_out,
  input logic [W-1:0] r_out,
  input logic [W-1:0] s_out,
  input logic         ovf_out,
  input logic         is_xfer,
  input logic         is_arith,
  input logic         writes_k,
  input logic         neg_wrap
);

  // R1: registers come out of reset cleared
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (j_out == '0 && k_out == '0 && r_out == '0 &&
                      s_out == '0 && !ovf_out));

  // R2: without a strobe nothing moves
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(j_out) && $stable(k_out) && $stable(r_out) &&
                   $stable(s_out) && $stable(ovf_out)));

  // R3: K is untouched when not a destination
  assert_k_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !writes_k) |=> $stable(k_out));

  // R7: only arithmetic words move the overflow bit
  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_arith) |=> $stable(ovf_out));

  // R7: negating the most negative value reports overflow
  assert_neg_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_arith && neg_wrap) |=> ovf_out);

  // R11: sub-accumulators move only under transfer words
  assert_sub_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_xfer) |=> ($stable(r_out) && $stable(s_out)));

  // R10: rotating the pair by one word width swaps J and K
  assert_pair_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_word == 12'o1374 && W == 12) |=>
      (j_out == $past(k_out) && k_out == $past(j_out)));

endmodule

bind ac_unit ac_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_word  (op_word),
  .j_out    (j_out),
  .k_out    (k_out),
  .r_out    (r_out),
  .s_out    (s_out),
  .ovf_out  (ovf_out),
  .is_xfer  (op_is_xfer),
  .is_arith (op_is_arith),
  .writes_k (op_writes_k),
  .neg_wrap (arith_neg_wrap)
);

// File: tb/test_ac_unit.sv
module test_ac_unit;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;
  localparam int N_STATES   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [11:0]   op_word = '0;
  logic [W-1:0]  switch_word = '0;
  logic [W-1:0]  j_out, k_out, r_out, s_out;
  logic          ovf_out;

  int checks = 0;
  int errors = 0;

  logic [11:0] mj, mk, mr, ms;
  logic        mov;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ac_unit #(.W(W)) i_ac_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_word     (op_word),
    .switch_word (switch_word),
    .j_out       (j_out),
    .k_out       (k_out),
    .r_out       (r_out),
    .s_out       (s_out),
    .ovf_out     (ovf_out)
  );

  function automatic int sval(input logic [11:0] v);
    return (int'(v) >= 2048) ? int'(v) - 4096 : int'(v);
  endfunction

  function automatic logic [11:0] pick(input int idx);
    case (idx % 8)
      0: return 12'd0;
      1: return 12'd1;
      2: return 12'd2047;
      3: return 12'd2048;
      4: return 12'd4095;
      5: return 12'o5252;
      6: return 12'o1234;
      default: return 12'o7001;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] ins, input logic v);
    int dest, mode, low;
    dest = int'(ins[7:6]);
    mode = int'(ins[5:4]);
    low  = int'(ins[3:0]);
    if (!v || ins[11:8] != 4'b0010) return "R2";
    if (mode == 0) begin
      if (dest == 0) return (low == 8) ? "R12" : "R2";
      if (low == 0) return "R4";
      if (low <= 3 || (low == 4 && dest == 2)) return "R11";
      return "R2";
    end
    if (mode == 1) return ins[3] ? "R6" : "R5";
    if (dest == 3) return "R10";
    if (dest == 0) return "R2";
    return (mode == 2) ? "R8" : "R9";
  endfunction

  // reference model, written from the requirements
  task automatic model_step(input logic [11:0] ins, input logic [11:0] sw);
    int dj, dk, mode, low, n, acc, res, r12, p, v;
    logic [11:0] t;
    bit ov;
    if (ins[11:8] != 4'b0010) return;
    dk = int'(ins[7]);
    dj = int'(ins[6]);
    mode = int'(ins[5:4]);
    low = int'(ins[3:0]);
    n = int'(ins[2:0]);
    if (mode == 0) begin
      if (dj == 0 && dk == 0) begin
        if (low == 8) mj = sw;
      end else if (low == 0) begin
        t = mj & mk;
        if (dj != 0) mj = t;
        if (dk != 0) mk = t;
      end else if (low == 1) begin
        if (dj != 0) mr = mj;
        if (dk != 0) ms = mk;
      end else if (low == 2) begin
        if (dj != 0) mj = mr;
        if (dk != 0) mk = ms;
      end else if (low == 3) begin
        if (dj != 0) begin t = mj; mj = mr; mr = t; end
        if (dk != 0) begin t = mk; mk = ms; ms = t; end
      end else if (low == 4 && dk != 0 && dj == 0) begin
        mk = mj;
      end
    end else if (mode == 1) begin
      if ((dj != 0 || dk != 0) && n <= 5 && !(dj != 0 && dk != 0 && n > 1)) begin
        acc = (dk != 0 && dj == 0) ? sval(mk) : sval(mj);
        case (n)
          0: res = sval(mj) + sval(mk);
          1: res = sval(mj) - sval(mk);
          2: res = sval(mr) + acc;
          3: res = sval(mr) - acc;
          4: res = sval(ms) + acc;
          default: res = sval(ms) - acc;
        endcase
        ov = (res > 2047) || (res < -2048);
        r12 = res & 4095;
        if (ins[3]) begin
          if (r12 == 2048) ov = 1'b1;
          r12 = (4096 - r12) & 4095;
        end
        if (dj != 0) mj = 12'(r12);
        if (dk != 0) mk = 12'(r12);
        mov = ov;
      end
    end else if (dj != 0 && dk != 0) begin
      p = int'(mj) * 4096 + int'(mk);
      for (int i = 0; i < low; i++)
        p = (mode == 2) ? ((p * 2) & 24'hFFFFFF)
                        : (((p * 2) & 24'hFFFFFF) | (p / 8388608));
      mj = 12'(p / 4096);
      mk = 12'(p % 4096);
    end else if (dj != 0 || dk != 0) begin
      v = (dj != 0) ? int'(mj) : int'(mk);
      for (int i = 0; i < low; i++)
        v = (mode == 2) ? ((v * 2) & 4095) : (((v * 2) & 4095) | (v / 2048));
      if (dj != 0) mj = 12'(v);
      else mk = 12'(v);
    end
  endtask

  task automatic compare(input string tag, input logic [11:0] ins);
    string jt, kt;
    checks++;
    jt = (ins[11:8] == 4'b0010 && ins[7:6] == 2'b10) ? "R3" : tag;
    kt = (ins[11:8] == 4'b0010 && ins[7:6] == 2'b01) ? "R3" : tag;
    if (j_out !== mj || k_out !== mk || r_out !== mr ||
        s_out !== ms || ovf_out !== mov) begin
      errors++;
      if (j_out !== mj)
        $display("FAIL %s word %o: J actual %o expected %o", jt, ins, j_out, mj);
      if (k_out !== mk)
        $display("FAIL %s word %o: K actual %o expected %o", kt, ins, k_out, mk);
      if (r_out !== mr)
        $display("FAIL R11 word %o: R actual %o expected %o", ins, r_out, mr);
      if (s_out !== ms)
        $display("FAIL R11 word %o: S actual %o expected %o", ins, s_out, ms);
      if (ovf_out !== mov)
        $display("FAIL R7 word %o: OV actual %b expected %b", ins, ovf_out, mov);
    end
  endtask

  // called at a falling edge; returns one cycle later at the next falling edge
  task automatic run(input logic [11:0] ins, input logic [11:0] sw, input logic v);
    op_valid    = v;
    op_word     = ins;
    switch_word = sw;
    if (v) model_step(ins, sw);
    @(negedge clk);
    op_valid = 1'b0;
    compare(tag_of(ins, v), ins);
  endtask

  task automatic setup(input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] c, input logic [11:0] d, input bit ov);
    run(12'o1010, ov ? 12'd2047 : 12'd0, 1'b1);  // R12
    run(12'o1204, 12'd0, 1'b1);                  // R11 K from J
    run(12'o1120, 12'd0, 1'b1);                  // R5/R7 sets or clears OV
    run(12'o1010, c, 1'b1);
    run(12'o1101, 12'd0, 1'b1);
    run(12'o1010, d, 1'b1);
    run(12'o1204, 12'd0, 1'b1);
    run(12'o1201, 12'd0, 1'b1);
    run(12'o1010, b, 1'b1);
    run(12'o1204, 12'd0, 1'b1);
    run(12'o1010, a, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired before the run completed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mj = '0; mk = '0; mr = '0; ms = '0; mov = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    compare("R1", 12'o0000);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 12'o0000);

    // every word of the group against a range of register states
    for (int st = 0; st < N_STATES; st++) begin
      for (int code = 0; code < 256; code++) begin
        setup(pick(st), pick(st * 3 + 1), pick(st * 5 + 2), pick(st * 7 + 5), st[0]);
        run(12'o1000 | 12'(code), pick(st + 3), 1'b1);
      end
    end

    // R2: strobe low, or words outside the group
    setup(12'o1234, 12'o4321, 12'o7070, 12'o0707, 1'b1);
    for (int i = 0; i < 64; i++)
      run(12'o1000 | 12'(i * 4 + 2), 12'o5555, 1'b0);
    run(12'o0000, 12'o5555, 1'b1);
    run(12'o0777, 12'o5555, 1'b1);
    run(12'o1400, 12'o5555, 1'b1);
    run(12'o1724, 12'o5555, 1'b1);
    run(12'o2000, 12'o5555, 1'b1);
    run(12'o7777, 12'o5555, 1'b1);

    // R10: explicit pair swap
    setup(12'o1111, 12'o6666, 12'd0, 12'd0, 1'b0);
    run(12'o1374, 12'd0, 1'b1);
    checks++;
    if (j_out !== 12'o6666 || k_out !== 12'o1111) begin
      errors++;
      $display("FAIL R10 swap: actual J=%o K=%o expected J=6666 K=1111", j_out, k_out);
    end

    // R7: negating -2048 from 0 - (-2048)... direct case: J=-2048, K=0, J+K negated
    setup(12'd2048, 12'd0, 12'd0, 12'd0, 1'b0);
    run(12'o1130, 12'd0, 1'b1);
    checks++;
    if (ovf_out !== 1'b1 || j_out !== 12'd2048) begin
      errors++;
      $display("FAIL R7 negate min: actual J=%o OV=%b expected J=4000 OV=1", j_out, ovf_out);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule